// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block sits between one in-order processor request port and a single-ported memory. Writes from the processor do not wait for memory. Stores go into a small first-in first-out queue that empties into memory, oldest entry first, one write per granted memory cycle. A load first compares its address against every pending store. If at least one matches, the load gets the data of the most recently issued matching store straight from the queue. If none matches, the load reads memory and passes over the unrelated older stores. A swap is atomic: it waits until the queue is empty, reads the old word, writes the new word, and returns the old word.

The processor port uses a valid/ready pair. After the block accepts a load or a swap, the port stays closed until the response has been delivered. Stores and swaps are also held back while the queue is full. The memory side has a grant input that says whether an access may take place in the current cycle. Read data comes back on the cycle after a granted read.

Top module: `store_fwd_buffer`

## Requirements
- R1: Right after reset, `req_ready` is 1 (for a load code), `resp_valid` is 0 and `mem_en` is 0.
- R2: Each store (`req_op` = 2'b01) is written to memory exactly once, with the address and data it was issued with. Stores and swap writes reach memory in issue order, and when all traffic has settled, memory holds the result of applying every write in program order.
- R3: A load (`req_op` = 2'b00; the reserved code 2'b11 also acts as a load) whose address matches one or more pending stores returns the data of the youngest match. `resp_valid` is high exactly one cycle after acceptance.
- R4: A load that matches no pending store returns the memory word at its address. When `mem_ready` stays high, `resp_valid` rises three cycles after acceptance. Every accepted load or swap produces exactly one response, and a store produces none.
- R5: While DEPTH stores are pending, stores and swaps are not accepted (`req_ready` is 0). Loads are still accepted.
- R6: From the cycle after a load or swap is accepted, through the cycle in which its `resp_valid` is high, `req_ready` stays 0.
- R7: `mem_en` is high only while `mem_ready` is high. If a missing load is accepted while stores are pending and memory is granted, that cycle's access is the write of the oldest pending store, and the load's read follows later.
- R8: A swap (`req_op` = 2'b10) starts its memory read only after every older store has been written. It returns the word it read, then writes its own data, and later loads of that address see the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present |
| req_op | input | 2 | 00 load, 01 store, 10 swap, 11 reserved (load) |
| req_addr | input | AW | Word address of the request |
| req_wdata | input | DW | Store or swap data |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| resp_valid | output | 1 | One-cycle strobe carrying a load or swap result |
| resp_data | output | DW | Load value or swap old value |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write (else a read) |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_ready | input | 1 | Memory port granted this cycle |
| mem_rdata | input | DW | Read data, valid the cycle after a granted read |

## Verification
The assertions rely on three assumptions about the block's inputs. Request fields stay stable while `req_valid` is high and not yet accepted. The reserved opcode never appears. Memory answers a granted read with data on the following cycle. The bench driver holds every field until it sees acceptance, its random traffic draws only the three defined codes, and its memory model registers read data on the granting edge. The grant input is switched between held-high, held-low and random patterns. This is what makes the queue fill and lets forwarding meet several matching stores.

// File: rtl/sq_pkg.sv
package sq_pkg;

  // Request operation codes seen on req_op.
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_SWAP  = 2'b10
  } sq_op_e;

  // Controller sequencing states.
  typedef enum logic [2:0] {
    S_IDLE     = 3'd0,
    S_LD_RD    = 3'd1,
    S_LD_WAIT  = 3'd2,
    S_SW_DRAIN = 3'd3,
    S_SW_CAP   = 3'd4,
    S_SW_WR    = 3'd5
  } sq_state_e;

endpackage

// File: rtl/sq_fifo.sv
module sq_fifo #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          push,
  input  logic [AW-1:0]                 push_addr,
  input  logic [DW-1:0]                 push_data,
  input  logic                          pop,
  output logic [AW-1:0]                 head_addr,
  output logic [DW-1:0]                 head_data,
  output logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] head_ptr,
  output logic [((DEPTH > 1) ? $clog2(DEPTH) : 1):0]   count,
  output logic                          full,
  output logic                          empty,
  output logic [DEPTH-1:0][AW-1:0]      slot_addr,
  output logic [DEPTH-1:0][DW-1:0]      slot_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = PW + 1;

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [PW-1:0] wr_ptr_q;
  logic [PW-1:0] rd_ptr_q;
  logic [CW-1:0] cnt_q;

  // Entry storage: written only at the tail, no reset on contents.
  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[wr_ptr_q] <= push_addr;
      data_q[wr_ptr_q] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push) wr_ptr_q <= wr_ptr_q + PW'(1);
      if (pop)  rd_ptr_q <= rd_ptr_q + PW'(1);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // Every slot is exposed so the address search can look at all of them.
  for (genvar g = 0; g < DEPTH; g++) begin : gen_slot
    assign slot_addr[g] = addr_q[g];
    assign slot_data[g] = data_q[g];
  end

  assign head_addr = addr_q[rd_ptr_q];
  assign head_data = data_q[rd_ptr_q];
  assign head_ptr  = rd_ptr_q;
  assign count     = cnt_q;
  assign full      = (cnt_q == CW'(DEPTH));
  assign empty     = (cnt_q == '0);

  // R5: the controller never pushes into a full queue.
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);

  // R2: the queue is never drained below empty.
  a_r2_no_underflow: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);

  // R2: a lone push raises the occupancy by exactly one.
  a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |=> (cnt_q == $past(cnt_q) + CW'(1)));

endmodule

// File: rtl/sq_match.sv
module sq_match #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic [DEPTH-1:0][AW-1:0]      slot_addr,
  input  logic [DEPTH-1:0][DW-1:0]      slot_data,
  input  logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] head_ptr,
  input  logic [((DEPTH > 1) ? $clog2(DEPTH) : 1):0]   count,
  input  logic [AW-1:0]                 look_addr,
  output logic                          hit,
  output logic [DW-1:0]                 hit_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = PW + 1;

  logic [DEPTH-1:0]         age_hit;
  logic [DEPTH-1:0][DW-1:0] age_data;

  // Rotate the physical slots into age order: position 0 is the oldest.
  for (genvar g = 0; g < DEPTH; g++) begin : gen_age
    logic [PW-1:0] idx;
    assign idx         = head_ptr + PW'(g);
    assign age_hit[g]  = (count > CW'(g)) && (slot_addr[idx] == look_addr);
    assign age_data[g] = slot_data[idx];
  end

  // Scan oldest to youngest so the last matching entry wins.
  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (age_hit[i]) begin
        hit      = 1'b1;
        hit_data = age_data[i];
      end
    end
  end

endmodule

// File: rtl/sq_ctrl.sv
module sq_ctrl
  import sq_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  input  logic          buf_full,
  input  logic          buf_empty,
  input  logic          fwd_hit,
  input  logic [DW-1:0] fwd_data,
  input  logic [AW-1:0] head_addr,
  input  logic [DW-1:0] head_data,
  output logic          buf_push,
  output logic          buf_pop,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          resp_valid,
  output logic [DW-1:0] resp_data
);
  sq_state_e     state_q;
  logic [AW-1:0] op_addr_q;
  logic [DW-1:0] op_data_q;
  logic          resp_valid_q;
  logic [DW-1:0] resp_data_q;

  logic is_store;
  logic is_swap;
  logic is_load;
  logic fire;
  logic drain_state;
  logic rd_now;
  logic wr_swap;

  assign is_store = (req_op == OP_STORE);
  assign is_swap  = (req_op == OP_SWAP);
  assign is_load  = !is_store && !is_swap;

  // Issue port: only in idle, never in a response cycle, writes need room.
  assign req_ready = (state_q == S_IDLE) && !resp_valid_q && (is_load || !buf_full);
  assign fire      = req_valid && req_ready;
  assign buf_push  = fire && is_store;

  // Drain may use the port in these states; a pending read or swap write
  // owns the port in the others.
  always_comb begin
    drain_state = 1'b0;
    if (state_q inside {S_IDLE, S_LD_WAIT, S_SW_DRAIN}) drain_state = 1'b1;
  end

  assign buf_pop = drain_state && !buf_empty && mem_ready;
  assign rd_now  = mem_ready &&
                   ((state_q == S_LD_RD) || ((state_q == S_SW_DRAIN) && buf_empty));
  assign wr_swap = mem_ready && ((state_q == S_SW_CAP) || (state_q == S_SW_WR));

  assign mem_en    = buf_pop || rd_now || wr_swap;
  assign mem_we    = buf_pop || wr_swap;
  assign mem_addr  = buf_pop ? head_addr : op_addr_q;
  assign mem_wdata = buf_pop ? head_data : op_data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= S_IDLE;
      op_addr_q    <= '0;
      op_data_q    <= '0;
      resp_valid_q <= 1'b0;
      resp_data_q  <= '0;
    end else begin
      resp_valid_q <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (fire && is_load) begin
            op_addr_q <= req_addr;
            if (fwd_hit) begin
              resp_valid_q <= 1'b1;
              resp_data_q  <= fwd_data;
            end else begin
              state_q <= S_LD_RD;
            end
          end else if (fire && is_swap) begin
            op_addr_q <= req_addr;
            op_data_q <= req_wdata;
            state_q   <= S_SW_DRAIN;
          end
        end
        S_LD_RD: begin
          if (mem_ready) state_q <= S_LD_WAIT;
        end
        S_LD_WAIT: begin
          resp_valid_q <= 1'b1;
          resp_data_q  <= mem_rdata;
          state_q      <= S_IDLE;
        end
        S_SW_DRAIN: begin
          if (buf_empty && mem_ready) state_q <= S_SW_CAP;
        end
        S_SW_CAP: begin
          resp_data_q <= mem_rdata;
          if (mem_ready) begin
            resp_valid_q <= 1'b1;
            state_q      <= S_IDLE;
          end else begin
            state_q <= S_SW_WR;
          end
        end
        S_SW_WR: begin
          if (mem_ready) begin
            resp_valid_q <= 1'b1;
            state_q      <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign resp_valid = resp_valid_q;
  assign resp_data  = resp_data_q;

  // R6: an accepted load or swap closes the port on the following cycle.
  a_r6_issue_closed: assert property (@(posedge clk) disable iff (rst)
    (fire && !is_store) |=> !fire);

  // R7: no memory access without a grant.
  a_r7_grant_only: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> mem_ready);

  // R8: the swap's read data is captured only when the queue is empty.
  a_r8_swap_after_drain: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_SW_CAP) |-> buf_empty);

  // R4: responses are single-cycle strobes, never back to back.
  a_r4_resp_pulse: assert property (@(posedge clk) disable iff (rst)
    resp_valid_q |=> !resp_valid_q);

endmodule

// File: rtl/store_fwd_buffer.sv
module store_fwd_buffer #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          resp_valid,
  output logic [DW-1:0] resp_data,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = PW + 1;

  logic                     push;
  logic                     pop;
  logic [AW-1:0]            head_addr;
  logic [DW-1:0]            head_data;
  logic [PW-1:0]            head_ptr;
  logic [CW-1:0]            count;
  logic                     full;
  logic                     empty;
  logic [DEPTH-1:0][AW-1:0] slot_addr;
  logic [DEPTH-1:0][DW-1:0] slot_data;
  logic                     hit;
  logic [DW-1:0]            hit_data;

  sq_fifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_addr (req_addr),
    .push_data (req_wdata),
    .pop       (pop),
    .head_addr (head_addr),
    .head_data (head_data),
    .head_ptr  (head_ptr),
    .count     (count),
    .full      (full),
    .empty     (empty),
    .slot_addr (slot_addr),
    .slot_data (slot_data)
  );

  sq_match #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_match (
    .slot_addr (slot_addr),
    .slot_data (slot_data),
    .head_ptr  (head_ptr),
    .count     (count),
    .look_addr (req_addr),
    .hit       (hit),
    .hit_data  (hit_data)
  );

  sq_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_ready  (req_ready),
    .buf_full   (full),
    .buf_empty  (empty),
    .fwd_hit    (hit),
    .fwd_data   (hit_data),
    .head_addr  (head_addr),
    .head_data  (head_data),
    .buf_push   (push),
    .buf_pop    (pop),
    .mem_ready  (mem_ready),
    .mem_rdata  (mem_rdata),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .resp_valid (resp_valid),
    .resp_data  (resp_data)
  );

  // R5: while the queue is full, the port refuses a store.
  a_r5_full_blocks_store: assert property (@(posedge clk) disable iff (rst)
    (full && req_op == 2'b01) |-> !req_ready);

endmodule

// File: tb/store_fwd_buffer_tb.sv
module store_fwd_buffer_tb;
  localparam int AW    = 8;
  localparam int DW    = 16;
  localparam int DEPTH = 4;
  localparam int MEMN  = 1 << AW;
  localparam logic [1:0] LD = 2'b00;
  localparam logic [1:0] ST = 2'b01;
  localparam logic [1:0] SW = 2'b10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = LD;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready;
  logic          resp_valid;
  logic [DW-1:0] resp_data;
  logic          mem_en;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_ready;
  logic [DW-1:0] mem_rdata = '0;

  logic rnd_mode = 1'b0;
  logic mr_force = 1'b1;
  logic rnd_bit  = 1'b1;
  assign mem_ready = rnd_mode ? rnd_bit : mr_force;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit outstanding = 0;
  bit finished = 0;

  logic [DW-1:0] mem_arr [MEMN];
  logic [DW-1:0] ref_mem [MEMN];

  logic [DW-1:0] exp_data_q [$];
  int            exp_cyc_q  [$];
  int            exp_req_q  [$];
  logic [AW-1:0] wr_addr_q  [$];
  logic [DW-1:0] wr_data_q  [$];
  logic [AW-1:0] pend_q     [$];

  store_fwd_buffer #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_data(resp_data), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  always #2 clk = ~clk;

  always @(posedge clk) cyc = cyc + 1;

  always @(posedge clk) begin
    #1;
    rnd_bit = ($urandom_range(0, 3) != 0);
  end

  // Memory model: one-cycle registered read.
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem_arr[mem_addr] <= mem_wdata;
      else        mem_rdata <= mem_arr[mem_addr];
    end
  end

  function automatic void chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endfunction

  // Reference model, compared every cycle at the falling edge.
  always @(negedge clk) begin : monitor
    logic hit_now;
    logic fire;
    int   kind;
    if (!rst && !finished) begin
      hit_now = 1'b0;
      for (int i = 0; i < pend_q.size(); i++)
        if (pend_q[i] == req_addr) hit_now = 1'b1;

      if (mem_en) chk(mem_ready, "R7 access without grant", mem_en, 0);

      if (outstanding) chk(!req_ready, "R6 port open while busy", req_ready, 0);

      if (req_valid && req_op != LD && pend_q.size() == DEPTH)
        chk(!req_ready, "R5 write accepted while full", req_ready, 0);

      if (resp_valid) begin
        if (exp_data_q.size() == 0) begin
          chk(1'b0, "R4 unexpected response", resp_data, 0);
        end else begin
          kind = exp_req_q.pop_front();
          if (kind == 3)      chk(resp_data == exp_data_q[0], "R3 forwarded value", resp_data, exp_data_q[0]);
          else if (kind == 4) chk(resp_data == exp_data_q[0], "R4 memory load value", resp_data, exp_data_q[0]);
          else                chk(resp_data == exp_data_q[0], "R8 swap old value", resp_data, exp_data_q[0]);
          void'(exp_data_q.pop_front());
          if (exp_cyc_q[0] >= 0)
            chk(cyc == exp_cyc_q[0], (kind == 3) ? "R3 response cycle" : "R4 response cycle", cyc, exp_cyc_q[0]);
          void'(exp_cyc_q.pop_front());
        end
        outstanding = 0;
      end

      fire = req_valid && req_ready;

      if (fire && req_op == LD && !hit_now && pend_q.size() > 0 && mem_ready)
        chk(mem_en && mem_we && mem_addr == pend_q[0], "R7 drain before load read",
            {mem_en, mem_we}, 3);

      if (mem_en && mem_we) begin
        if (wr_addr_q.size() == 0) begin
          chk(1'b0, "R2 unexpected write", mem_addr, 0);
        end else begin
          chk(mem_addr == wr_addr_q[0], "R2 write address order", mem_addr, wr_addr_q[0]);
          chk(mem_wdata == wr_data_q[0], "R2 write data order", mem_wdata, wr_data_q[0]);
          void'(wr_addr_q.pop_front());
          void'(wr_data_q.pop_front());
          if (pend_q.size() > 0) void'(pend_q.pop_front());
        end
      end

      if (fire) begin
        if (req_op == ST) begin
          ref_mem[req_addr] = req_wdata;
          wr_addr_q.push_back(req_addr);
          wr_data_q.push_back(req_wdata);
          pend_q.push_back(req_addr);
        end else if (req_op == SW) begin
          exp_data_q.push_back(ref_mem[req_addr]);
          exp_cyc_q.push_back(-1);
          exp_req_q.push_back(8);
          ref_mem[req_addr] = req_wdata;
          wr_addr_q.push_back(req_addr);
          wr_data_q.push_back(req_wdata);
          outstanding = 1;
        end else begin
          exp_data_q.push_back(ref_mem[req_addr]);
          if (hit_now) begin
            exp_cyc_q.push_back(cyc + 1);
            exp_req_q.push_back(3);
          end else begin
            exp_cyc_q.push_back((!rnd_mode && mem_ready) ? cyc + 3 : -1);
            exp_req_q.push_back(4);
          end
          outstanding = 1;
        end
      end
    end
  end

  task automatic issue(input logic [1:0] op, input int a, input int d);
    req_valid = 1'b1;
    req_op    = op;
    req_addr  = AW'(a);
    req_wdata = DW'(d);
    do @(negedge clk); while (!req_ready);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    req_op    = LD;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    repeat (60000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stimulus
    int mism;
    for (int i = 0; i < MEMN; i++) begin
      mem_arr[i] = DW'(i * 257) ^ DW'(16'h5A5A);
      ref_mem[i] = DW'(i * 257) ^ DW'(16'h5A5A);
    end
    repeat (4) @(posedge clk);
    #1;
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(resp_valid == 1'b0, "R1 no response after reset", resp_valid, 0);
    chk(mem_en == 1'b0, "R1 memory quiet after reset", mem_en, 0);
    @(posedge clk);
    #1;

    // R4: miss with an empty queue.
    issue(LD, 9, 0);
    idle(5);
    // R3: store then load of the same word while the store drains.
    issue(ST, 5, 16'h1111);
    issue(LD, 5, 0);
    idle(4);

    // R3: several matches held in the queue; youngest wins.
    mr_force = 1'b0;
    issue(ST, 7, 16'hA001);
    issue(ST, 8, 16'hB002);
    issue(ST, 7, 16'hC003);
    issue(LD, 7, 0);
    idle(2);
    issue(LD, 8, 0);
    idle(2);
    // R5: fill the queue, load still accepted, next store blocked.
    issue(ST, 12, 16'hD004);
    issue(LD, 7, 0);
    idle(2);
    fork
      issue(ST, 13, 16'hE005);
      begin
        idle(6);
        mr_force = 1'b1;
      end
    join
    idle(8);
    // R4: read back a drained word from memory.
    issue(LD, 7, 0);
    idle(5);

    // R8: swap behind a pending store, then a load sees the new word.
    issue(ST, 3, 16'h0AAA);
    issue(SW, 3, 16'h0BBB);
    idle(2);
    issue(LD, 3, 0);
    idle(5);
    // R8: swap waits for a blocked drain.
    mr_force = 1'b0;
    issue(ST, 10, 16'h1234);
    issue(ST, 11, 16'h5678);
    fork
      issue(SW, 10, 16'h9ABC);
      begin
        idle(5);
        mr_force = 1'b1;
      end
    join
    idle(4);
    issue(LD, 10, 0);
    idle(5);
    // R7: a miss while stores are pending lets the drain go first.
    issue(ST, 20, 16'h2020);
    issue(ST, 21, 16'h2121);
    issue(LD, 30, 0);
    idle(5);

    // Mixed random traffic with a random grant.
    rnd_mode = 1'b1;
    for (int n = 0; n < 500; n++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 4)      issue(ST, $urandom_range(0, 7), $urandom);
      else if (r < 8) issue(LD, $urandom_range(0, 7), 0);
      else            issue(SW, $urandom_range(0, 7), $urandom);
      if ($urandom_range(0, 4) == 0) idle($urandom_range(1, 3));
    end
    rnd_mode = 1'b0;
    mr_force = 1'b1;
    idle(30);

    chk(exp_data_q.size() == 0, "R4 missing responses", exp_data_q.size(), 0);
    chk(wr_addr_q.size() == 0, "R2 writes never drained", wr_addr_q.size(), 0);
    mism = 0;
    for (int i = 0; i < MEMN; i++)
      if (mem_arr[i] !== ref_mem[i]) mism++;
    chk(mism == 0, "R2 final memory image", mism, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule